// File: doc/BRIEF.md
# Guarded Feature-Enable Register

This block holds a 64-bit control word whose bits switch on groups of architectural state. Software changes the word through one write port. Every write is screened against a fixed set of cross-bit consistency rules and against a supported-feature mask that the surrounding implementation drives. A write that passes all rules is loaded on the next clock edge. A write that breaks any rule is discarded, and the block raises a single-cycle fault pulse so that the requester can signal an error.

The bit assignments carry meaning, so their positions are fixed:
- Bit 0 is the mandatory base-state enable.
- Bit 1 enables base vector state.
- Bit 2 enables wide vector state.
- Bits 3 and 4 form the bound-register pair.
- Bits 5 to 7 form the extended-vector group.
- Bit 9 enables management of the protection-key rights state.

The current word is always visible on the read port.

Top module: `sereg_top`

## Requirements
- R1: After reset, and at all times while reset is held, the read port shows 0x1 (bit 0 set, all other bits clear) and the fault output is 0.
- R2: A write that breaks no rule is visible on the read port from the first clock edge after the one that samples it, and no fault pulse follows it.
- R3: A write that sets any bit that is 0 in the supported-feature mask (as sampled with the write) is rejected.
- R4: A write with bit 0 clear is rejected.
- R5: A write with bit 2 set and bit 1 clear is rejected.
- R6: A write with bit 2 clear and any of bits 5, 6 or 7 set is rejected.
- R7: A write in which bits 3 and 4 differ is rejected.
- R8: A write in which bits 5, 6 and 7 are not all equal is rejected.
- R9: A rejected write leaves the register unchanged. It drives the fault output high for exactly the one cycle after the edge that samples it.
- R10: In a cycle without a write request, the register holds its value and no fault pulse follows.
- R11: Bit 9 behaves as an ordinary enable. It is written whenever the mask supports it and the other rules pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request, sampled on the rising edge |
| wrData | input | 64 | Proposed new register value |
| supportMask | input | 64 | 1 for each bit this implementation provides |
| rdData | output | 64 | Current register value |
| faultPulse | output | 1 | High for one cycle after a rejected write |

## Verification
Two events can fall in the same cycle: the fault pulse from a rejected write, and the sampling of a following legal write. The bench provokes this by holding the write request high over two consecutive cycles, first with an illegal word and then with a legal one. It then judges two things. The pulse must be present while the second write is being sampled and gone once it lands. The register must keep the old value through the pulse and take the new value only on the following edge. A change of the supported-feature mask between two writes of the same word also checks that the mask is read together with each write.

// File: rtl/sereg_pkg.sv
package sereg_pkg;

  // Bit positions the rules depend on
  localparam int BIT_BASE    = 0;
  localparam int BIT_VEC     = 1;
  localparam int BIT_WIDE    = 2;
  localparam int BIT_PAIR_LO = 3;
  localparam int BIT_PAIR_HI = 4;
  localparam int BIT_GRP_LO  = 5;
  localparam int BIT_GRP_HI  = 7;
  localparam int BIT_PKEY    = 9;
  localparam int MIN_WIDTH   = BIT_PKEY + 1;

  typedef enum int unsigned {
    RULE_UNSUP = 0,
    RULE_BASE  = 1,
    RULE_VEC   = 2,
    RULE_WIDE  = 3,
    RULE_PAIR  = 4,
    RULE_GROUP = 5,
    RULE_COUNT = 6
  } ruleIdx_e;

  // Strobes from the checker to the storage
  typedef struct packed {
    logic load;
    logic fault;
  } ctlStrobe_t;

endpackage

// File: rtl/sereg_check.sv
module sereg_check
  import sereg_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] supportMask,
  output ctlStrobe_t       strobe
);

  localparam int GRP_W = BIT_GRP_HI - BIT_GRP_LO + 1;

  logic [RULE_COUNT-1:0] ruleHit;
  logic [GRP_W-1:0]      grpBits;
  logic                  anyHit;

  assign grpBits = wrData[BIT_GRP_HI:BIT_GRP_LO];

  // One violation flag per rule
  always_comb begin
    ruleHit             = '0;
    ruleHit[RULE_UNSUP] = |(wrData & ~supportMask);
    ruleHit[RULE_BASE]  = !wrData[BIT_BASE];
    ruleHit[RULE_VEC]   = wrData[BIT_WIDE] && !wrData[BIT_VEC];
    ruleHit[RULE_WIDE]  = !wrData[BIT_WIDE] && (|grpBits);
    ruleHit[RULE_PAIR]  = wrData[BIT_PAIR_LO] ^ wrData[BIT_PAIR_HI];
    ruleHit[RULE_GROUP] = (|grpBits) && !(&grpBits);
  end

  assign anyHit       = |ruleHit;
  assign strobe.load  = wrEn && !anyHit;
  assign strobe.fault = wrEn && anyHit;

  initial begin
    assert (WIDTH >= MIN_WIDTH)
      else $error("sereg_check: WIDTH below %0d", MIN_WIDTH);
  end

endmodule

// File: rtl/sereg_store.sv
module sereg_store
  import sereg_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] regQ,
  output logic             faultQ
);

  localparam logic [WIDTH-1:0] RESET_VAL = WIDTH'(1) << BIT_BASE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ   <= RESET_VAL;
      faultQ <= 1'b0;
    end else begin
      if (strobe.load) regQ <= wrData;
      faultQ <= strobe.fault;
    end
  end

  // R2: an accepted write lands on the next edge
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (regQ == $past(wrData)) && !faultQ);

  // R9: the register does not move across a rejected write
  assert_hold_on_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |-> (regQ == $past(regQ)));

  // R4: the base enable never drops
  assert_base_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    regQ[BIT_BASE]);

  // R5: wide vector state never enabled without base vector state
  assert_vec_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(regQ[BIT_WIDE] && !regQ[BIT_VEC]));

  // R7: the pair bits always agree
  assert_pair_equal_R7: assert property (@(posedge clk) disable iff (!rstN)
    regQ[BIT_PAIR_LO] == regQ[BIT_PAIR_HI]);

  // R8: the group bits are all set or all clear
  assert_group_uniform_R8: assert property (@(posedge clk) disable iff (!rstN)
    (&regQ[BIT_GRP_HI:BIT_GRP_LO]) || !(|regQ[BIT_GRP_HI:BIT_GRP_LO]));

endmodule

// File: rtl/sereg_top.sv
module sereg_top
  import sereg_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] supportMask,
  output logic [WIDTH-1:0] rdData,
  output logic             faultPulse
);

  ctlStrobe_t strobe;

  sereg_check #(.WIDTH(WIDTH)) i_check (
    .wrEn        (wrEn),
    .wrData      (wrData),
    .supportMask (supportMask),
    .strobe      (strobe)
  );

  sereg_store #(.WIDTH(WIDTH)) i_store (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .regQ   (rdData),
    .faultQ (faultPulse)
  );

  // R10: no request, no change and no pulse
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !faultPulse && $stable(rdData));

  // R9: a pulse only ever follows a request
  assert_fault_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> $past(wrEn));

  // R3: a word with an unsupported bit never lands
  assert_unsup_blocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && |(wrData & ~supportMask)) |=> faultPulse);

endmodule

// File: tb/test_sereg_top.sv
module test_sereg_top;

  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] supportMask = 64'h2FF;
  logic [W-1:0] rdData;
  logic         faultPulse;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  logic [W-1:0] model = 64'h1;

  typedef struct {
    logic [W-1:0] val;
    bit           flt;
    string        tag;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  sereg_top #(.WIDTH(W)) i_sereg_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .supportMask(supportMask), .rdData(rdData), .faultPulse(faultPulse)
  );

  task automatic checkVal(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Driver: presents one write for one cycle and records the expected outcome
  task automatic doWrite(input logic [W-1:0] d, input bit expFault, input string tag);
    expItem_t it;
    if (!expFault) model = d;
    it.val = model;
    it.flt = expFault;
    it.tag = tag;
    expQ.push_back(it);
    wrEn   = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // One idle cycle: no pulse, register unchanged
  task automatic idleCheck(input string tag);
    @(negedge clk);
    #2;
    checkVal({tag, " pulse"}, {63'b0, faultPulse}, 64'h0);
    checkVal({tag, " value"}, rdData, model);
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    @(negedge clk);
    #1;
    checkVal("R1 reset value", rdData, 64'h1);
    checkVal("R1 reset pulse", {63'b0, faultPulse}, 64'h0);
    model = 64'h1;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Monitor: pops and compares after every sampled write
  initial begin
    forever begin
      bit took;
      @(posedge clk);
      took = wrEn && rstN;
      @(negedge clk);
      #1;
      if (took) begin
        expItem_t it;
        if (expQ.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL scoreboard empty actual=1 expected=0");
        end else begin
          it = expQ.pop_front();
          checkVal({it.tag, " value"}, rdData, it.val);
          checkVal({it.tag, " pulse"}, {63'b0, faultPulse}, {63'b0, it.flt});
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    applyReset();

    doWrite(64'h3,   1'b0, "R2 legal 0x3");
    doWrite(64'h7,   1'b0, "R2 legal 0x7");
    doWrite(64'hE7,  1'b0, "R8 full group");
    doWrite(64'h1F,  1'b0, "R7 full pair");
    doWrite(64'h207, 1'b0, "R11 bit9 set");
    idleCheck("R10 idle");

    doWrite(64'h6,   1'b1, "R4 base clear");
    idleCheck("R9 one cycle");
    doWrite(64'h205, 1'b1, "R5 wide without vec");
    doWrite(64'hE3,  1'b1, "R6 group without wide");
    doWrite(64'hF,   1'b1, "R7 pair lo only");
    doWrite(64'h17,  1'b1, "R7 pair hi only");
    doWrite(64'h27,  1'b1, "R8 partial group");
    doWrite(64'hC7,  1'b1, "R8 two of group");
    doWrite(64'h103, 1'b1, "R3 bit8 unsupported");
    doWrite(64'h1 | (64'h1 << 40), 1'b1, "R3 bit40 unsupported");
    idleCheck("R9 after faults");

    // Back-to-back: rejected write then legal write
    doWrite(64'h5, 1'b1, "R9 reject before accept");
    doWrite(64'h3, 1'b0, "R2 accept after reject");
    doWrite(64'h1, 1'b0, "R2 drop to base");
    idleCheck("R10 idle after burst");

    // Mask read with each write
    doWrite(64'h201, 1'b0, "R11 bit9 supported");
    supportMask = 64'h1FF;
    doWrite(64'h201, 1'b1, "R3 bit9 now unsupported");
    doWrite(64'h103, 1'b0, "R3 bit8 now supported");
    idleCheck("R10 idle final");

    applyReset();
    idleCheck("R1 after second reset");

    repeat (2) @(negedge clk);
    checkVal("scoreboard drained", 64'(expQ.size()), 64'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule